// File: doc/BRIEF.md
# Handshake-Synchronized Data Register

This block carries a multi-bit word from one clock domain to another without a FIFO. A producer in the source domain writes a word when the block says it is ready. The word is latched into a source-side holding register, and a single phase bit is flipped in the same cycle. That phase bit crosses into the destination domain through a flop chain. When the synchronized phase differs from the destination's remembered phase, the destination loads the holding register into its output register. Because the holding register cannot change until the destination has taken it, every bit of the word is stable when it is captured.

The destination's remembered phase is sent back to the source through another flop chain. The source becomes ready again only when that returned phase matches its own phase. So a new write is accepted only after the previous one is visible at the destination output. Only the most recent accepted write is ever shown. Writes offered while the block is busy are dropped, and the destination cannot push back.

Each domain has its own synchronous active-low reset. While held in reset, the holding register and the output register both load a parameterized reset value.

Top module: `xdom_reg`

## Requirements
- R1: While `src_rst_n` is low, `wr_rdy` is 0 and the holding register loads `RESET_VALUE`. While `dst_rst_n` is low, `rd_data` loads `RESET_VALUE`.
- R2: After both resets are released with no write offered, `wr_rdy` becomes 1 within SYNC_STAGES+2 source cycles.
- R3: A write is accepted at a source clock edge where `wr_en` and `wr_rdy` are both 1. The holding register takes `wr_data` at that edge, and `wr_rdy` is 0 in the following source cycle.
- R4: A write offered while `wr_rdy` is 0 leaves the holding register unchanged and is never shown at `rd_data`.
- R5: `rd_data` changes only on a destination edge where the synchronized handshake pulse is high. On that edge it takes the holding register's value; at all other edges it holds.
- R6: Every accepted write appears at `rd_data` exactly once, in acceptance order, as the whole word with no mix of old and new bits. This holds whether the destination clock is faster or slower than the source clock.
- R7: After an accepted write, `wr_rdy` returns to 1 only once `rd_data` already shows that write.
- R8: An accepted write appears at `rd_data` within SYNC_STAGES+2 destination rising edges after the accepting source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous reset, active low |
| wr_en | input | 1 | Write request; acted on only when `wr_rdy` is 1 |
| wr_data | input | WIDTH | Word to transfer |
| wr_rdy | output | 1 | High when a write would be accepted at the next source edge |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain synchronous reset, active low |
| rd_data | output | WIDTH | Most recently delivered word, registered in the destination domain |

## Verification
A phase bit that is out of step between the two domains shows up in one of two ways. The destination may load the holding register with no write behind it, which appears as an unexpected or repeated word at `rd_data` within SYNC_STAGES+2 destination edges. Or the source may never become ready again, which appears as `wr_rdy` stuck low well past the round-trip time. If the ready path returns too early, the source accepts a write while the previous one is still in flight, and `rd_data` then skips words. A holding register that follows `wr_data` while busy puts an unaccepted or torn word on `rd_data` at the next capture. The benches run these cases with the destination clock faster than, slower than and close to the source clock, so order and whole-word delivery are checked for each ratio.

// File: rtl/xdom_reg_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the handshake-synchronized register.
// Assumes: nothing beyond IEEE 1800-2017.
package xdom_reg_pkg;

    // Fewest flops allowed in any crossing chain.
    localparam int unsigned XDR_MIN_SYNC = 2;

    // Opposite handshake phase; used for reset values that must mismatch.
    function automatic logic phase_flip(input logic p);
        return ~p;
    endfunction

endpackage

// File: rtl/xdom_reg_sync.sv
`timescale 1ns/1ps
// Multi-flop single-bit synchronizer with synchronous active-low reset.
// Assumes: d is a level from another domain that changes at most once
// per handshake, so only the settling delay matters, not the data value.
module xdom_reg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop: sample the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= d;
            end
        end else begin : g_next
            // Later flops: let a metastable value settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xdom_reg_launch.sv
`timescale 1ns/1ps
// Source half of the toggle handshake. An accepted request flips the
// phase bit and drops ready. Ready comes back once the phase returned
// by the destination matches the local phase again.
// Assumes: echo_async is the destination's remembered phase (the
// delayed-return form), so ready rises only after the destination has
// already used the transfer.
module xdom_reg_launch
    import xdom_reg_pkg::*;
#(
    parameter int unsigned STAGES     = 2,
    parameter logic        INIT_PHASE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic echo_async,
    output logic phase,
    output logic ready,
    output logic accept
);

    logic echo_sync;

    // The returned phase resets to the opposite value, so ready starts low.
    xdom_reg_sync #(
        .STAGES  (STAGES),
        .RST_VAL (phase_flip(INIT_PHASE))
    ) u_echo_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (echo_async),
        .q     (echo_sync)
    );

    // A request counts only while ready is high.
    assign accept = req & ready;

    // Flip the phase on accept; otherwise work out ready from the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= INIT_PHASE;
            ready <= 1'b0;
        end else if (accept) begin
            phase <= phase_flip(phase);
            ready <= 1'b0;
        end else begin
            ready <= (echo_sync == phase);
        end
    end

endmodule

// File: rtl/xdom_reg_land.sv
`timescale 1ns/1ps
// Destination half of the toggle handshake. The incoming phase is
// synchronized and compared with the last phase seen. A difference gives
// a one-cycle capture pulse. The remembered phase is sent back to the
// source.
// Assumes: phase_async flips at most once per round trip.
module xdom_reg_land #(
    parameter int unsigned STAGES     = 2,
    parameter logic        INIT_PHASE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_async,
    output logic pulse,
    output logic last_phase
);

    logic phase_sync;

    xdom_reg_sync #(
        .STAGES  (STAGES),
        .RST_VAL (INIT_PHASE)
    ) u_fwd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (phase_async),
        .q     (phase_sync)
    );

    // Remember the synchronized phase one cycle later, so a change lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_phase <= INIT_PHASE;
        else        last_phase <= phase_sync;
    end

    assign pulse = phase_sync ^ last_phase;

endmodule

// File: rtl/xdom_reg.sv
`timescale 1ns/1ps
// Handshake-synchronized data register (top level).
// The source domain writes a word into a holding register and starts a
// toggle handshake. The destination loads that word into rd_data on the
// synchronized pulse. wr_rdy blocks further writes until the destination
// has taken the word.
// Assumes: each domain's reset is synchronous to its own clock. Both
// resets are applied together when the block is started.
module xdom_reg
    import xdom_reg_pkg::*;
#(
    parameter int unsigned      WIDTH       = 32,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VALUE = '0,
    parameter logic             INIT_PHASE  = 1'b0
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_rdy,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [WIDTH-1:0] rd_data
);

    // Never build a chain shorter than the allowed minimum.
    localparam int unsigned EFF_STAGES =
        (SYNC_STAGES < XDR_MIN_SYNC) ? XDR_MIN_SYNC : SYNC_STAGES;

    logic             src_phase;
    logic             src_accept;
    logic             dst_last;
    logic             cap_pulse;
    logic [WIDTH-1:0] hold_q;

    xdom_reg_launch #(
        .STAGES     (EFF_STAGES),
        .INIT_PHASE (INIT_PHASE)
    ) u_launch (
        .clk        (src_clk),
        .rst_n      (src_rst_n),
        .req        (wr_en),
        .echo_async (dst_last),
        .phase      (src_phase),
        .ready      (wr_rdy),
        .accept     (src_accept)
    );

    // Holding register: loads only on an accepted write, held otherwise.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)      hold_q <= RESET_VALUE;
        else if (src_accept) hold_q <= wr_data;
    end

    xdom_reg_land #(
        .STAGES     (EFF_STAGES),
        .INIT_PHASE (INIT_PHASE)
    ) u_land (
        .clk         (dst_clk),
        .rst_n       (dst_rst_n),
        .phase_async (src_phase),
        .pulse       (cap_pulse),
        .last_phase  (dst_last)
    );

    // Destination output: takes the stable holding register on the pulse.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n)     rd_data <= RESET_VALUE;
        else if (cap_pulse) rd_data <= hold_q;
    end

endmodule

// File: rtl/xdom_reg_chk.sv
`timescale 1ns/1ps
// Protocol checker for xdom_reg, attached with bind.
// Assumes: it is connected to the top's ports and to its internal
// holding register and capture pulse.
module xdom_reg_chk #(
    parameter int unsigned      WIDTH       = 32,
    parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             wr_rdy,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] hold_q,
    input logic             cap_pulse
);

    // R1: source reset forces ready low and the holding register to the reset value.
    a_r1_src_reset: assert property (@(posedge src_clk)
        !src_rst_n |=> (!wr_rdy && hold_q == RESET_VALUE));

    // R1: destination reset loads the reset value into the output.
    a_r1_dst_reset: assert property (@(posedge dst_clk)
        !dst_rst_n |=> rd_data == RESET_VALUE);

    // R3: an accepted write loads the holding register and drops ready.
    a_r3_accept: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (wr_en && wr_rdy) |=> (!wr_rdy && hold_q == $past(wr_data)));

    // R4: the holding register does not move without an accepted write.
    a_r4_hold_stable: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !(wr_en && wr_rdy) |=> $stable(hold_q));

    // R5: the output changes only on a capture pulse.
    a_r5_out_on_pulse: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !$stable(rd_data) |-> $past(cap_pulse));

    // R5: on a pulse the output takes the holding register.
    a_r5_out_loads: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        cap_pulse |=> rd_data == $past(hold_q));

    // R6: each transfer gives a single-cycle pulse, so it is captured once.
    a_r6_single_pulse: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        cap_pulse |=> !cap_pulse);

endmodule

bind xdom_reg xdom_reg_chk #(
    .WIDTH       (WIDTH),
    .RESET_VALUE (RESET_VALUE)
) u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_rdy    (wr_rdy),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .rd_data   (rd_data),
    .hold_q    (hold_q),
    .cap_pulse (cap_pulse)
);

// File: tb/xdom_reg_test.sv
`timescale 1ns/1ps
// Directed bench for xdom_reg. There is one task per scenario, and each
// task checks its own results. A destination-side monitor checks order
// and whole-word delivery against a queue of accepted writes.
module xdom_reg_test;

    localparam int unsigned W      = 32;
    localparam int unsigned STG    = 2;
    localparam logic [W-1:0] RSTV  = 32'hA5A5_0F0F;
    localparam int unsigned LAT    = STG + 2;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_rdy;
    logic [W-1:0] rd_data;

    int           dst_half = 7;
    int           checks = 0;
    int           fails = 0;
    bit           mon_on = 1'b0;
    bit           done = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] seen;

    xdom_reg #(
        .WIDTH       (W),
        .SYNC_STAGES (STG),
        .RESET_VALUE (RSTV)
    ) uut (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_rdy    (wr_rdy),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .rd_data   (rd_data)
    );

    // 100 MHz source clock.
    always #5 src_clk = ~src_clk;
    // Destination clock with a period the tests change.
    always begin
        #(dst_half);
        dst_clk = ~dst_clk;
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R6 monitor: every change of rd_data must be the oldest pending accepted write.
    always @(negedge dst_clk) begin
        if (mon_on && rd_data !== seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 word shown without a pending write", rd_data, seen);
            end else begin
                chk(rd_data == exp_q[0], "R6 order or torn word", rd_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
            seen = rd_data;
        end
    end

    // Reset both domains, check reset values (R1) and the return of ready (R2).
    task automatic do_reset();
        int n;
        mon_on    = 1'b0;
        wr_en     = 1'b0;
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        repeat (4) @(posedge src_clk);
        repeat (4) @(posedge dst_clk);
        @(negedge src_clk);
        chk(wr_rdy == 1'b0, "R1 wr_rdy low in reset", W'(wr_rdy), '0);
        chk(rd_data == RSTV, "R1 rd_data reset value", rd_data, RSTV);
        exp_q.delete();
        seen      = RSTV;
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        mon_on    = 1'b1;
        n = 0;
        while (!wr_rdy && n < 10) begin
            @(negedge src_clk);
            n++;
        end
        chk(wr_rdy && n <= LAT, "R2 ready after reset", W'(n), W'(LAT));
        chk(rd_data == RSTV, "R1 rd_data holds reset value", rd_data, RSTV);
    endtask

    // Single write: R3 ready drop, R8 latency, R7 ready only after delivery.
    task automatic write_one(input logic [W-1:0] v);
        int w;
        int n;
        @(negedge src_clk);
        w = 0;
        while (!wr_rdy && w < 400) begin
            @(negedge src_clk);
            w++;
        end
        wr_en   = 1'b1;
        wr_data = v;
        exp_q.push_back(v);
        @(posedge src_clk);
        fork
            begin
                @(negedge src_clk);
                wr_en = 1'b0;
                chk(wr_rdy == 1'b0, "R3 ready drops after accept", W'(wr_rdy), '0);
            end
            begin
                n = 0;
                while (rd_data != v && n < 10) begin
                    @(posedge dst_clk);
                    #1;
                    n++;
                end
                chk(rd_data == v && n <= LAT, "R8 delivery latency", W'(n), W'(LAT));
            end
        join
        w = 0;
        while (!wr_rdy && w < 400) begin
            @(negedge src_clk);
            w++;
        end
        chk(wr_rdy == 1'b1, "R7 ready returns", W'(wr_rdy), W'(1));
        chk(rd_data == v, "R7 delivered before ready", rd_data, v);
    endtask

    // Writes offered while busy must be dropped (R4) and the output holds (R5).
    task automatic busy_write(input logic [W-1:0] v, input logic [W-1:0] junk);
        int k;
        write_one(v);
        wr_en   = 1'b1;
        wr_data = v ^ 32'h0000_FFFF;
        exp_q.push_back(wr_data);
        @(posedge src_clk);
        k = 0;
        forever begin
            @(negedge src_clk);
            if (wr_rdy) begin
                wr_en = 1'b0;
                break;
            end
            wr_en   = 1'b1;
            wr_data = junk + W'(k);
            k++;
        end
        repeat (12) @(posedge dst_clk);
        #1;
        chk(rd_data == (v ^ 32'h0000_FFFF), "R4 busy writes not shown", rd_data,
            v ^ 32'h0000_FFFF);
        chk(exp_q.size() == 0, "R5 output held after capture", W'(exp_q.size()), '0);
    endtask

    // Stream: wr_en held high, accepted exactly when wr_rdy is seen high (R3, R6).
    task automatic stream(input int n_acc, input logic [W-1:0] base);
        int cnt;
        int cyc;
        int w;
        cnt = 0;
        cyc = 0;
        while (cnt < n_acc) begin
            @(negedge src_clk);
            wr_en   = 1'b1;
            wr_data = base + W'(cyc * 32'h0101_0101);
            cyc++;
            if (wr_rdy) begin
                exp_q.push_back(wr_data);
                cnt++;
            end
        end
        @(negedge src_clk);
        wr_en = 1'b0;
        w = 0;
        while (exp_q.size() != 0 && w < 4000) begin
            @(posedge src_clk);
            w++;
        end
        #1;
        chk(exp_q.size() == 0, "R6 all accepted writes delivered", W'(exp_q.size()), '0);
    endtask

    initial begin
        dst_half = 7;
        do_reset();
        write_one(32'h1234_5678);
        write_one(32'hEDCB_A987);
        write_one(32'hFFFF_FFFF);
        write_one(32'h0000_0000);
        busy_write(32'h5A5A_3C3C, 32'hDEAD_0000);
        stream(16, 32'h1000_0001);
        dst_half = 2;                 // destination faster than source
        stream(16, 32'h2000_0003);
        write_one(32'hC0FF_EE00);
        dst_half = 26;                // destination much slower than source
        stream(10, 32'h3000_0005);
        write_one(32'h0F0F_F0F0);
        dst_half = 5;                 // same period as the source; edges may line up
        stream(12, 32'h4000_0007);
        busy_write(32'h7777_8888, 32'hBEEF_0000);
        do_reset();                   // R1: reset in mid-run after traffic
        write_one(32'h1357_9BDF);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge src_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule